// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Access Classes

This block is a target on a two-wire serial bus (I2C) that lets a host reach a 256-byte register space. The host first sends a device address byte. A strap input picks one of two 7-bit device addresses. When the direction bit of that byte is clear, the next byte sets an internal pointer, and any further bytes are written starting at that pointer. To read, the host sets the pointer in a write phase, then sends a repeated START and the address with the direction bit set. The block then returns bytes until the host stops acknowledging. The pointer moves forward by one after every data byte, in either direction.

A fixed table gives every subaddress one of three access classes: read/write, read-only or reserved. Read/write locations are kept in internal storage. Read-only locations are not stored. Their values come from the surrounding logic through a status port, which the block addresses with its current pointer. Reserved locations hold nothing. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `i2c_regfile_slave`

## Requirements
- R1: With `addr_strap` low, the block acknowledges the address byte 0x42 (direction bit 0 = host writes) and the address byte 0x43 (direction bit 1 = host reads).
- R2: With `addr_strap` high, the block acknowledges 0x40 and 0x41, and it does not acknowledge 0x42.
- R3: After an address byte that does not match, the block gives no acknowledge and leaves SDA released for every later byte until the next START.
- R4: In a write, the subaddress byte and each data byte are acknowledged. A data byte sent to a read/write location (0x01–0x19, 0x30–0x3A, 0x40–0x60, 0x80–0xEF) is stored and is returned by a later read.
- R5: The pointer advances by one after each data byte that is written or read, and it wraps from 0xFF to 0x00.
- R6: A read starts with a write phase that sets the pointer. After a repeated START and the read address, the block sends bytes MSB first. It stops sending when the host does not acknowledge a byte.
- R7: Subaddresses 0x00, 0x1F, 0x61 and 0x62 are read-only. A read returns `stat_data` while `stat_addr` carries that subaddress. A write to them is acknowledged and changes nothing.
- R8: Every other subaddress is reserved (0x1A–0x1E, 0x20–0x2F, 0x3B–0x3F, 0x63–0x7F, 0xF0–0xFF). A write to them is acknowledged and changes nothing, and a read returns 0x00.
- R9: `sda_oe` changes only while SCL is low.
- R10: A STOP returns the block to idle with SDA released. A byte clocked after the STOP without a new START is not acknowledged.
- R11: After reset, SDA is released and every read/write location reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it runs much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 1 | Picks the alternate device address when high |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND level) |
| sda_oe | output | 1 | Pulls SDA low when high; SDA is released when low |
| stat_addr | output | 8 | Subaddress for which a read-only status byte is wanted |
| stat_data | input | 8 | Status byte for `stat_addr` |

## Verification
A table of single-byte writes, each followed by a read-back, covers every access class. The read-back value tells apart a byte that was stored, a byte taken from the status port and a location that yields zero. Multi-byte bursts placed across a class boundary and across the 0xFF end of the space show whether the pointer advances and wraps, and whether write protection is applied byte by byte rather than once per transfer. Address bytes that match, that do not match, and that match only under the other strap setting separate the two address decodes, and they show whether a rejected target stays off the bus. A monitor counts any change of `sda_oe` while SCL is high.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam int REG_N  = 1 << REG_AW;

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_RO  = 2'd1,
    ACC_RSV = 2'd2
  } acc_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_SUB   = 3'd2,
    ST_WDATA = 3'd3,
    ST_ACK   = 3'd4,
    ST_RDATA = 3'd5,
    ST_RACK  = 3'd6
  } st_t;

  // Read-only single locations
  localparam logic [REG_AW-1:0] RO_VERSION = 8'h00;
  localparam logic [REG_AW-1:0] RO_DECSTAT = 8'h1F;
  localparam logic [REG_AW-1:0] RO_SLC_LO  = 8'h61;
  localparam logic [REG_AW-1:0] RO_SLC_HI  = 8'h62;

  // Read/write windows (inclusive)
  localparam logic [REG_AW-1:0] RW0_LO = 8'h01, RW0_HI = 8'h19;
  localparam logic [REG_AW-1:0] RW1_LO = 8'h30, RW1_HI = 8'h3A;
  localparam logic [REG_AW-1:0] RW2_LO = 8'h40, RW2_HI = 8'h60;
  localparam logic [REG_AW-1:0] RW3_LO = 8'h80, RW3_HI = 8'hEF;

  function automatic logic in_win(input logic [REG_AW-1:0] a,
                                  input logic [REG_AW-1:0] lo,
                                  input logic [REG_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic acc_t acc_class(input logic [REG_AW-1:0] a);
    if (a == RO_VERSION || a == RO_DECSTAT ||
        (a >= RO_SLC_LO && a <= RO_SLC_HI))
      return ACC_RO;
    if (in_win(a, RW0_LO, RW0_HI) || in_win(a, RW1_LO, RW1_HI) ||
        in_win(a, RW2_LO, RW2_HI) || in_win(a, RW3_LO, RW3_HI))
      return ACC_RW;
    return ACC_RSV;
  endfunction

  // Seven-bit device address chosen by the strap
  function automatic logic [6:0] dev_sel(input logic strap,
                                         input logic [6:0] main_a,
                                         input logic [6:0] alt_a);
    return strap ? alt_a : main_a;
  endfunction

endpackage

// File: rtl/i2c_rf_line_sync.sv
module i2c_rf_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rf_access_map.sv
module i2c_rf_access_map
  import i2c_rf_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  output acc_t              cls
);
  assign cls = acc_class(addr);
endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store
  import i2c_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wr_data,
  input  acc_t              cls,
  input  logic [REG_DW-1:0] stat_data,
  output logic [REG_DW-1:0] rd_data
);
  logic [REG_DW-1:0] mem [REG_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) mem[i] <= '0;
    end else if (wr_en && cls == ACC_RW) begin
      mem[addr] <= wr_data;
    end
  end

  always_comb begin
    case (cls)
      ACC_RW:  rd_data = mem[addr];
      ACC_RO:  rd_data = stat_data;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_MAIN = 7'h21,
  parameter logic [6:0] DEV_ADDR_ALT  = 7'h20,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strap,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [REG_AW-1:0] stat_addr,
  input  logic [REG_DW-1:0] stat_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  st_t               st, after_st;
  logic [2:0]        bcnt;
  logic [6:0]        shreg;
  logic [REG_DW-1:0] tx;
  logic [REG_AW-1:0] ptr;
  logic              ack_ph;

  // Named events for the checker
  logic              rx_phase, byte_done, addr_match, wr_fire;
  logic [REG_DW-1:0] rx_byte, rd_data;
  acc_t              rd_cls;

  assign rx_phase   = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WDATA);
  assign byte_done  = rx_phase && scl_rise && (bcnt == 3'd7);
  assign rx_byte    = {shreg, sda_s};
  assign addr_match = rx_byte[7:1] == dev_sel(addr_strap, DEV_ADDR_MAIN, DEV_ADDR_ALT);
  assign wr_fire    = byte_done && (st == ST_WDATA);
  assign stat_addr  = ptr;

  i2c_rf_access_map u_map (.addr(ptr), .cls(rd_cls));

  i2c_rf_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .addr(ptr),
    .wr_data(rx_byte), .cls(rd_cls), .stat_data(stat_data), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      after_st <= ST_IDLE;
      bcnt     <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      ack_ph   <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      bcnt   <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise) begin
            shreg <= {shreg[5:0], sda_s};
            bcnt  <= bcnt + 3'd1;
          end
          if (byte_done) begin
            case (st)
              ST_ADDR: begin
                if (addr_match) begin
                  st       <= ST_ACK;
                  after_st <= rx_byte[0] ? ST_RDATA : ST_SUB;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_SUB: begin
                ptr      <= rx_byte;
                st       <= ST_ACK;
                after_st <= ST_WDATA;
              end
              default: begin
                ptr      <= ptr + 1'b1;
                st       <= ST_ACK;
                after_st <= ST_WDATA;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_ph) begin
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
            end else begin
              ack_ph <= 1'b0;
              bcnt   <= '0;
              st     <= after_st;
              if (after_st == ST_RDATA) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bcnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
              ptr    <= ptr + 1'b1;
            end else begin
              bcnt   <= bcnt + 3'd1;
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            st <= ST_IDLE;
          end else if (scl_fall) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            bcnt   <= '0;
            st     <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk
  import i2c_rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input st_t               st,
  input logic [REG_AW-1:0] ptr,
  input logic              byte_done,
  input logic              addr_match,
  input logic              stop_det,
  input acc_t              rd_cls,
  input logic [REG_DW-1:0] rd_data
);
  p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_ADDR && !addr_match) |=> (st == ST_IDLE && !sda_oe));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  p_wr_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_WDATA) |=> (ptr == $past(ptr) + 8'd1));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cls == ACC_RSV) |-> (rd_data == '0));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe));
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .st(st),
  .ptr(ptr), .byte_done(byte_done), .addr_match(addr_match),
  .stop_det(stop_det), .rd_cls(rd_cls), .rd_data(rd_data)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic       sda_oe;
  logic [7:0] stat_addr, stat_data;
  wire        sda_line = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0, viol = 0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  always #4 clk = ~clk;

  // Status source: a value the bench can predict from the subaddress
  assign stat_data = stat_addr ^ 8'h5A;

  i2c_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_i(scl_h),
    .sda_i(sda_line), .sda_oe(sda_oe), .stat_addr(stat_addr), .stat_data(stat_data)
  );

  // R9 monitor: output drive may only move while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_h) viol++;
    oe_prev <= sda_oe;
  end

  // kind: 0 read/write, 1 read-only, 2 reserved ; {kind, sub, data}
  localparam logic [17:0] VEC [12] = '{
    {2'd0, 8'h05, 8'h3C}, {2'd1, 8'h00, 8'h11}, {2'd2, 8'h1C, 8'h77},
    {2'd0, 8'h30, 8'h81}, {2'd2, 8'h3B, 8'h12}, {2'd1, 8'h61, 8'h55},
    {2'd0, 8'h80, 8'hEE}, {2'd2, 8'hF5, 8'h99}, {2'd0, 8'h60, 8'h42},
    {2'd2, 8'h2F, 8'h10}, {2'd1, 8'h1F, 8'h24}, {2'd0, 8'hEF, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; w(Q);
    scl_h = 1'b1; w(Q);
    sda_h = 1'b0; w(Q);
    scl_h = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; w(Q);
    scl_h = 1'b1; w(Q);
    sda_h = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; w(Q);
      scl_h = 1'b1; w(2*Q);
      scl_h = 1'b0; w(Q);
    end
    sda_h = 1'b1; w(Q);
    scl_h = 1'b1; w(Q);
    ack = sda_line; w(Q);
    scl_h = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      scl_h = 1'b1; w(Q);
      b[i] = sda_line; w(Q);
      scl_h = 1'b0;
    end
    w(Q);
    sda_h = last; w(Q);
    scl_h = 1'b1; w(2*Q);
    scl_h = 1'b0; w(Q);
    sda_h = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] sub,
                        input int n, input string req);
    logic a;
    bus_start();
    send_byte(dev, a);    chk(a == 1'b0, req, {7'd0, a}, 8'h00);
    send_byte(sub, a);    chk(a == 1'b0, req, {7'd0, a}, 8'h00);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk(a == 1'b0, req, {7'd0, a}, 8'h00);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] dev, input logic [7:0] sub,
                        input int n, input string req);
    logic a;
    bus_start();
    send_byte(dev, a);          chk(a == 1'b0, req, {7'd0, a}, 8'h00);
    send_byte(sub, a);          chk(a == 1'b0, req, {7'd0, a}, 8'h00);
    bus_start();
    send_byte(dev | 8'h01, a);  chk(a == 1'b0, req, {7'd0, a}, 8'h00);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    bus_stop();
    chk(sda_oe == 1'b0, {req, " release"}, {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] exp;
    w(5);
    // R11: reset state
    chk(sda_oe == 1'b0, "R11 sda released in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1; w(5);
    chk(sda_oe == 1'b0, "R11 sda released", {7'd0, sda_oe}, 8'h00);
    rd_txn(8'h42, 8'h01, 3, "R11");
    for (int k = 0; k < 3; k++) chk(rbuf[k] == 8'h00, "R11 cleared", rbuf[k], 8'h00);

    // Table walk: R1 R4 R6 R7 R8 single byte write then read back
    for (int v = 0; v < 12; v++) begin
      wbuf[0] = VEC[v][7:0];
      wr_txn(8'h42, VEC[v][15:8], 1, "R1 R4 write ack");
      rd_txn(8'h42, VEC[v][15:8], 1, "R1 R6 read ack");
      case (VEC[v][17:16])
        2'd0:    exp = VEC[v][7:0];
        2'd1:    exp = VEC[v][15:8] ^ 8'h5A;
        default: exp = 8'h00;
      endcase
      chk(rbuf[0] == exp, VEC[v][17:16] == 2'd0 ? "R4 stored" :
          VEC[v][17:16] == 2'd1 ? "R7 read-only" : "R8 reserved", rbuf[0], exp);
    end

    // R5 and R8: burst across the 0x19/0x1A class boundary
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    wr_txn(8'h42, 8'h18, 3, "R5 burst write");
    rd_txn(8'h42, 8'h18, 3, "R5 burst read");
    chk(rbuf[0] == 8'hA1, "R5 byte0", rbuf[0], 8'hA1);
    chk(rbuf[1] == 8'hA2, "R5 byte1", rbuf[1], 8'hA2);
    chk(rbuf[2] == 8'h00, "R8 byte2 reserved", rbuf[2], 8'h00);

    // R5: read wraps 0xFF -> 0x00 (0x00 is read-only status)
    rd_txn(8'h42, 8'hFF, 2, "R5 wrap");
    chk(rbuf[0] == 8'h00, "R5 at FF", rbuf[0], 8'h00);
    chk(rbuf[1] == 8'h5A, "R5 wrapped to 00", rbuf[1], 8'h5A);

    // R5: write burst wraps, first byte lands at 0x01 after 0xFF and 0x00
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h6D;
    wr_txn(8'h42, 8'hFF, 3, "R5 wrap write");
    rd_txn(8'h42, 8'h01, 1, "R5 wrap write read");
    chk(rbuf[0] == 8'h6D, "R5 write wrapped", rbuf[0], 8'h6D);

    // R3: non-matching address
    bus_start();
    send_byte(8'h50, a); chk(a == 1'b1, "R3 no ack", {7'd0, a}, 8'h01);
    send_byte(8'h00, a); chk(a == 1'b1, "R3 stays off bus", {7'd0, a}, 8'h01);
    bus_stop();

    // R10: STOP returns to idle
    bus_start();
    send_byte(8'h42, a); chk(a == 1'b0, "R10 addr ack", {7'd0, a}, 8'h00);
    bus_stop();
    chk(sda_oe == 1'b0, "R10 released", {7'd0, sda_oe}, 8'h00);
    send_byte(8'h42, a); chk(a == 1'b1, "R10 idle after stop", {7'd0, a}, 8'h01);
    bus_stop();

    // R2: alternate address under strap
    strap = 1'b1; w(4);
    bus_start();
    send_byte(8'h42, a); chk(a == 1'b1, "R2 main addr rejected", {7'd0, a}, 8'h01);
    bus_stop();
    wbuf[0] = 8'h5E;
    wr_txn(8'h40, 8'h45, 1, "R2 alt write");
    rd_txn(8'h40, 8'h45, 1, "R2 alt read");
    chk(rbuf[0] == 8'h5E, "R2 alt data", rbuf[0], 8'h5E);
    strap = 1'b0; w(4);

    chk(viol == 0, "R9 sda moved while scl high", viol[7:0], 8'h00);
    finish_run();
  end
endmodule